// File: doc/BRIEF.md
# Bit-Serial I2C Engine

This block connects a processor to a two-wire I2C bus at the level of single bits. It cleans up the clock and data lines, tracks whether a transfer is open, captures the data line on each clock pulse and raises a request to software after every bit. Assembling bytes, matching addresses and choosing an arbitration policy are left to software, which steps the bus one bit at a time. Both lines are open-drain: the block only asserts an enable that pulls the line low, or releases it.

Each clock pulse ends on a falling edge. On that edge, while a transfer is open, the block raises `bit_irq` and updates two flags. `rx_full` says that a bit was received cleanly. `tx_empty` says that the bit offered by software also appeared on the bus. After the edge the clock is held low until software clears the request. In slave mode this holding is done by stretching the clock. In master mode the block generates the clock itself from programmable low and high times. The high time is counted only once the bus actually reads high, so a slave that stretches the clock lengthens the pulse.

The bus monitor has the states `LN_FREE` and `LN_BUSY`. It moves from free to busy on a START and from busy to free on a STOP. The master clock generator has five states:

- `MS_IDLE` releases the clock. It goes to `MS_HIGH` on a START.
- `MS_HIGH` counts the high time, then goes to `MS_HOLD`.
- `MS_HOLD` drives the clock low until the request is cleared, then goes to `MS_LOW`.
- `MS_LOW` counts the low time, then goes to `MS_WAIT_HI`.
- `MS_WAIT_HI` releases the clock and waits for the bus to read high. It then goes to `MS_HIGH`, or to `MS_IDLE` if a release was requested.

A STOP, or leaving master mode, returns the generator to `MS_IDLE` from any state.

Top module: `bit_i2c_engine`

## Requirements
- R1: Each line passes a two-flop synchroniser and then a filter that takes a new level only after FLT_LEN (default 3) equal consecutive samples. A line change lasting fewer than FLT_LEN clocks creates no START, no STOP, no clock edge and no request.
- R2: A falling SDA while the filtered SCL is high (START) sets `bus_busy`.
- R3: `bit_irq` is set on every falling edge of the filtered SCL while `bus_busy` is 1, which includes the first falling edge after a START. A falling edge while `bus_busy` is 0 leaves `bit_irq` at 0.
- R4: A rising SDA while the filtered SCL is high (STOP) clears `bus_busy`. Later clock edges raise no request.
- R5: On each rising edge of the filtered SCL, `rx_bit` takes the filtered SDA level.
- R6: On a requesting falling edge, `rx_full` becomes 1 only if a rising edge occurred since the previous falling edge with no START or STOP in between. The first falling edge after a START therefore gives 0. `rx_ack` clears `rx_full`, but a falling edge in the same cycle wins.
- R7: `tx_wr` loads `tx_bit_in` and clears `tx_empty`. On a requesting falling edge, `tx_empty` becomes 1 only if the pulse was clean (as in R6) and `rx_bit` equals the loaded bit. `tx_empty` is 1 after reset.
- R8: `sda_oe` is 1 exactly when the loaded transmit bit is 0. The transmit bit is 1 after reset.
- R9: In slave mode `scl_oe` is 1 while `bit_irq` is 1, so the clock is stretched. `irq_clr` clears `bit_irq`, but a falling edge in the same cycle keeps it set.
- R10: In master mode, once `irq_clr` is taken in `MS_HOLD`, `scl_oe` stays 1 for exactly `cfg_tlow` clocks and is then released.
- R11: In master mode, a released clock is driven low again `FLT_LEN + 3 + cfg_thigh` clocks after release. Any time the bus holds SCL low adds the same number of clocks.
- R12: In master mode, a START makes the block drive SCL low after the high time, which leads to the first request. An `irq_clr` with `mst_release` set leaves SCL released after the low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Clock line as read from the bus |
| sda_i | input | 1 | Data line as read from the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_master | input | 1 | 1 selects master clock generation, 0 selects slave |
| cfg_thigh | input | TW | Master SCL high time in clocks (0 acts as 1) |
| cfg_tlow | input | TW | Master SCL low time in clocks (0 acts as 1) |
| tx_wr | input | 1 | Strobe that loads the next transmit bit |
| tx_bit_in | input | 1 | Transmit bit value |
| rx_ack | input | 1 | Strobe that clears `rx_full` |
| irq_clr | input | 1 | Strobe that clears `bit_irq` and releases the hold |
| mst_release | input | 1 | With `irq_clr` in master mode: release the bus after this low phase |
| bit_irq | output | 1 | Per-bit service request |
| rx_bit | output | 1 | SDA level latched on the last SCL rising edge |
| rx_full | output | 1 | Last bit was received cleanly |
| tx_empty | output | 1 | Last bit was transmitted as loaded |
| bus_busy | output | 1 | A transfer is open between START and STOP |

## Verification
Two functions can fall in the same cycle: the falling edge that updates the flags and the request, and a software strobe (`rx_ack` or `irq_clr`) that clears them. The bench works out from the filter depth the exact clock at which a falling SCL reaches the flag logic. It places both strobes on that clock and then expects `rx_full` and `bit_irq` to still be 1. A second strobe one cycle later shows that the clear works on its own. The master timing sweep covers the other pairing: a pulled-low bus while the generator waits in `MS_WAIT_HI`, judged by counting released clocks.

// File: rtl/bit_i2c_pkg.sv
package bit_i2c_pkg;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_HIGH,
        MS_HOLD,
        MS_LOW,
        MS_WAIT_HI
    } mst_state_e;

    typedef enum logic {
        LN_FREE,
        LN_BUSY
    } line_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_SCL  = 0;
    localparam int unsigned LINE_SDA  = 1;

endpackage

// File: rtl/bit_i2c_filter.sv
module bit_i2c_filter #(
    parameter int unsigned FLT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int unsigned CW = (FLT_LEN < 2) ? 1 : $clog2(FLT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FLT_LEN - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            run_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean_q) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                clean_q <= sync_q[1];
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign clean = clean_q;

endmodule

// File: rtl/bit_i2c_monitor.sv
module bit_i2c_monitor
    import bit_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt,
    output logic     busy,
    output logic     rx_bit,
    output logic     pulse_ok
);
    line_state_e state_q, state_d;
    logic        scl_prev_q, sda_prev_q;
    logic        rx_bit_q, pulse_ok_q;

    always_comb begin
        evt.rise  = scl_f & ~scl_prev_q;
        evt.fall  = ~scl_f & scl_prev_q;
        evt.start = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
        evt.stop  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_FREE: if (evt.start) state_d = LN_BUSY;
            LN_BUSY: if (evt.stop)  state_d = LN_FREE;
            default:                state_d = LN_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
            rx_bit_q   <= 1'b1;
            pulse_ok_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
            if (evt.rise) begin
                rx_bit_q <= sda_f;
            end
            if (evt.start || evt.stop) begin
                pulse_ok_q <= 1'b0;
            end else if (evt.rise) begin
                pulse_ok_q <= 1'b1;
            end else if (evt.fall) begin
                pulse_ok_q <= 1'b0;
            end
        end
    end

    assign busy     = (state_q == LN_BUSY);
    assign rx_bit   = rx_bit_q;
    assign pulse_ok = pulse_ok_q;

endmodule

// File: rtl/bit_i2c_sclgen.sv
module bit_i2c_sclgen
    import bit_i2c_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] thigh,
    input  logic [TW-1:0] tlow,
    input  logic          scl_f,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic          irq_q,
    input  logic          irq_clr,
    input  logic          release_req,
    output logic          scl_drive
);
    mst_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          rel_q, rel_d;
    logic          high_done, low_done;

    assign high_done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, thigh};
    assign low_done  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, tlow};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
            rel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rel_q   <= rel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rel_d   = rel_q;
        if (!enable || stop_evt) begin
            state_d = MS_IDLE;
            cnt_d   = '0;
            rel_d   = 1'b0;
        end else begin
            unique case (state_q)
                MS_IDLE: begin
                    if (start_evt) begin
                        state_d = MS_HIGH;
                        cnt_d   = '0;
                    end
                end
                MS_HIGH: begin
                    if (high_done) begin
                        state_d = MS_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                MS_HOLD: begin
                    if (irq_q && irq_clr) begin
                        state_d = MS_LOW;
                        cnt_d   = '0;
                        rel_d   = release_req;
                    end
                end
                MS_LOW: begin
                    if (low_done) begin
                        state_d = MS_WAIT_HI;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                MS_WAIT_HI: begin
                    if (scl_f) begin
                        state_d = rel_q ? MS_IDLE : MS_HIGH;
                        cnt_d   = '0;
                        rel_d   = 1'b0;
                    end
                end
                default: begin
                    state_d = MS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            MS_HOLD, MS_LOW: scl_drive = 1'b1;
            default:         scl_drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/bit_i2c_engine.sv
module bit_i2c_engine
    import bit_i2c_pkg::*;
#(
    parameter int unsigned FLT_LEN = 3,
    parameter int unsigned TW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          cfg_master,
    input  logic [TW-1:0] cfg_thigh,
    input  logic [TW-1:0] cfg_tlow,
    input  logic          tx_wr,
    input  logic          tx_bit_in,
    input  logic          rx_ack,
    input  logic          irq_clr,
    input  logic          mst_release,
    output logic          bit_irq,
    output logic          rx_bit,
    output logic          rx_full,
    output logic          tx_empty,
    output logic          bus_busy
);
    logic [NUM_LINES-1:0] raw_v, clean_v;
    logic                 scl_f, sda_f;
    bus_evt_t             evt;
    logic                 pulse_ok, busy, rx_bit_w;
    logic                 scl_drive;
    logic                 irq_q, rx_full_q, tx_empty_q, tx_bit_q;
    logic                 bit_edge;

    assign raw_v[LINE_SCL] = scl_i;
    assign raw_v[LINE_SDA] = sda_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        bit_i2c_filter #(.FLT_LEN(FLT_LEN)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_v[g]),
            .clean (clean_v[g])
        );
    end

    assign scl_f = clean_v[LINE_SCL];
    assign sda_f = clean_v[LINE_SDA];

    bit_i2c_monitor u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .evt      (evt),
        .busy     (busy),
        .rx_bit   (rx_bit_w),
        .pulse_ok (pulse_ok)
    );

    bit_i2c_sclgen #(.TW(TW)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_master),
        .thigh       (cfg_thigh),
        .tlow        (cfg_tlow),
        .scl_f       (scl_f),
        .start_evt   (evt.start),
        .stop_evt    (evt.stop),
        .irq_q       (irq_q),
        .irq_clr     (irq_clr),
        .release_req (mst_release),
        .scl_drive   (scl_drive)
    );

    assign bit_edge = evt.fall & busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q      <= 1'b0;
            rx_full_q  <= 1'b0;
            tx_empty_q <= 1'b1;
            tx_bit_q   <= 1'b1;
        end else begin
            if (bit_edge) begin
                irq_q <= 1'b1;
            end else if (irq_clr) begin
                irq_q <= 1'b0;
            end
            if (bit_edge) begin
                rx_full_q <= pulse_ok;
            end else if (rx_ack) begin
                rx_full_q <= 1'b0;
            end
            if (bit_edge) begin
                tx_empty_q <= pulse_ok & (rx_bit_w == tx_bit_q);
            end else if (tx_wr) begin
                tx_empty_q <= 1'b0;
            end
            if (tx_wr) begin
                tx_bit_q <= tx_bit_in;
            end
        end
    end

    assign scl_oe   = cfg_master ? scl_drive : irq_q;
    assign sda_oe   = ~tx_bit_q;
    assign bit_irq  = irq_q;
    assign rx_bit   = rx_bit_w;
    assign rx_full  = rx_full_q;
    assign tx_empty = tx_empty_q;
    assign bus_busy = busy;

endmodule

// File: rtl/bit_i2c_checker.sv
module bit_i2c_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic irq_clr,
    input logic scl_oe,
    input logic bit_irq,
    input logic rx_full,
    input logic bus_busy,
    input logic scl_f
);
    AST_BUSY_ON_HIGH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(scl_f)); // R2

    AST_REQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_irq) |-> ($past(scl_f, 2) && !$past(scl_f))); // R3

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_irq) |-> $past(bus_busy)); // R3

    AST_FREE_ON_HIGH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> $past(scl_f)); // R4

    AST_FULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> ($past(scl_f, 2) && !$past(scl_f))); // R6

    AST_CLEAR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bit_irq) |-> $past(irq_clr)); // R9

    AST_MASTER_PULL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $past(cfg_master) && $rose(scl_oe)) |-> $past(scl_f)); // R11

endmodule

bind bit_i2c_engine bit_i2c_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .irq_clr    (irq_clr),
    .scl_oe     (scl_oe),
    .bit_irq    (bit_irq),
    .rx_full    (rx_full),
    .bus_busy   (bus_busy),
    .scl_f      (scl_f)
);

// File: tb/bit_i2c_engine_test.sv
module bit_i2c_engine_test;
    localparam int CLK_P   = 10;
    localparam int FLT     = 3;
    localparam int TWB     = 8;
    localparam int PH      = 12;
    localparam int STRETCH = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic scl_oe, sda_oe;
    logic cfg_master = 1'b0;
    logic [TWB-1:0] cfg_thigh = 8'd2, cfg_tlow = 8'd2;
    logic tx_wr = 1'b0, tx_bit_in = 1'b1, rx_ack = 1'b0, irq_clr = 1'b0, mst_release = 1'b0;
    logic bit_irq, rx_bit, rx_full, tx_empty, bus_busy;
    logic scl_bus, sda_bus;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    assign scl_bus = scl_drv & ~scl_oe;
    assign sda_bus = sda_drv & ~sda_oe;

    always #(CLK_P / 2) clk = ~clk;

    bit_i2c_engine #(.FLT_LEN(FLT), .TW(TWB)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_master(cfg_master),
        .cfg_thigh(cfg_thigh), .cfg_tlow(cfg_tlow), .tx_wr(tx_wr),
        .tx_bit_in(tx_bit_in), .rx_ack(rx_ack), .irq_clr(irq_clr),
        .mst_release(mst_release), .bit_irq(bit_irq), .rx_bit(rx_bit),
        .rx_full(rx_full), .tx_empty(tx_empty), .bus_busy(bus_busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic b);
        @(negedge clk);
        tx_bit_in = b;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_clr(input logic rel);
        @(negedge clk);
        irq_clr = 1'b1;
        mst_release = rel;
        @(negedge clk);
        irq_clr = 1'b0;
        mst_release = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 400 && !bit_irq; i++) @(negedge clk);
    endtask

    task automatic s_start();
        sda_drv = 1'b1; scl_drv = 1'b1; cycles(PH);
        sda_drv = 1'b0; cycles(PH);
        scl_drv = 1'b0; cycles(PH);
    endtask

    task automatic s_clock(input logic b);
        sda_drv = b; cycles(PH);
        scl_drv = 1'b1;
        for (int i = 0; i < 400 && !scl_bus; i++) @(negedge clk);
        cycles(PH);
        scl_drv = 1'b0; cycles(PH);
    endtask

    task automatic s_stop();
        sda_drv = 1'b0; cycles(PH);
        scl_drv = 1'b1; cycles(PH);
        sda_drv = 1'b1; cycles(PH);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0 (run did not finish)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int m, n;
        logic rxe;
        cycles(5);
        rst_n = 1'b1;
        cycles(2);
        // Reset state
        check("R3 reset irq", bit_irq, 0);
        check("R6 reset rx_full", rx_full, 0);
        check("R7 reset tx_empty", tx_empty, 1);
        check("R8 reset sda_oe", sda_oe, 0);
        check("R2 reset busy", bus_busy, 0);
        check("R9 reset scl_oe", scl_oe, 0);

        // R3: clock pulses with no open transfer raise no request
        scl_drv = 1'b0; cycles(PH); scl_drv = 1'b1; cycles(PH);
        check("R3 idle fall no irq", bit_irq, 0);

        // Slave: START then first falling edge
        s_start();
        check("R2 busy after start", bus_busy, 1);
        check("R3 irq after first fall", bit_irq, 1);
        check("R6 first fall not full", rx_full, 0);
        check("R9 stretch on irq", scl_oe, 1);

        // Slave sweep over transmit bit and bus level
        for (int tx = 0; tx < 2; tx++) begin
            for (int drv = 0; drv < 2; drv++) begin
                do_wr(tx[0]);
                check("R7 write clears empty", tx_empty, 0);
                check("R8 sda drive", sda_oe, tx == 0 ? 1 : 0);
                pulse_clr(1'b0);
                check("R9 clear releases", scl_oe, 0);
                s_clock(drv[0]);
                rxe = tx[0] & drv[0];
                check("R5 sampled bit", rx_bit, rxe);
                check("R6 clean bit full", rx_full, 1);
                check("R7 tx match", tx_empty, (rxe == tx[0]) ? 1 : 0);
                check("R3 irq per bit", bit_irq, 1);
                pulse_ack();
                check("R6 ack clears", rx_full, 0);
            end
        end

        // R9: stretch holds against a released master clock
        scl_drv = 1'b1; cycles(40);
        check("R9 bus held low", scl_bus, 0);
        check("R9 irq kept", bit_irq, 1);
        scl_drv = 1'b0;
        pulse_clr(1'b0);

        // R1: short glitches are ignored
        do_wr(1'b1);
        sda_drv = 1'b1; cycles(PH);
        scl_drv = 1'b1; cycles(PH);
        sda_drv = 1'b0; cycles(FLT - 1); sda_drv = 1'b1; cycles(PH);
        check("R1 sda glitch no event", bus_busy, 1);
        scl_drv = 1'b0; cycles(FLT - 1); scl_drv = 1'b1; cycles(PH);
        check("R1 scl glitch no irq", bit_irq, 0);
        scl_drv = 1'b0; cycles(PH);
        check("R1 real fall irq", bit_irq, 1);
        check("R1 pulse kept clean", rx_full, 1);

        // Coincidence: clear strobes in the same cycle as the falling edge
        pulse_clr(1'b0);
        sda_drv = 1'b1; cycles(PH);
        scl_drv = 1'b1; cycles(PH);
        scl_drv = 1'b0;
        repeat (FLT + 2) @(posedge clk);
        @(negedge clk);
        rx_ack = 1'b1; irq_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_ack = 1'b0; irq_clr = 1'b0;
        check("R6 fall wins over ack", rx_full, 1);
        check("R9 fall wins over clear", bit_irq, 1);
        pulse_ack();
        check("R6 ack alone clears", rx_full, 0);
        pulse_clr(1'b0);

        // R4: STOP closes the transfer
        s_stop();
        check("R4 stop frees bus", bus_busy, 0);
        scl_drv = 1'b0; cycles(PH); scl_drv = 1'b1; cycles(PH);
        check("R4 no irq after stop", bit_irq, 0);

        // Master sweep over high and low times
        cfg_master = 1'b1;
        for (int th = 1; th <= 3; th++) begin
            for (int tl = 1; tl <= 3; tl += 2) begin
                cfg_thigh = TWB'(th);
                cfg_tlow  = TWB'(tl);
                do_wr(1'b0);
                wait_irq();
                check("R12 start leads to irq", bit_irq, 1);
                check("R12 held low", scl_oe, 1);
                check("R2 master busy", bus_busy, 1);
                check("R6 master first fall", rx_full, 0);
                do_wr(1'b1);
                @(negedge clk);
                irq_clr = 1'b1;
                @(posedge clk);
                @(negedge clk);
                irq_clr = 1'b0;
                n = 0;
                while (scl_oe && n < 100) begin n++; @(negedge clk); end
                check("R10 low time", n, tl);
                m = 0;
                while (!scl_oe && m < 100) begin
                    if (th == 2 && m == 0) scl_drv = 1'b0;
                    if (th == 2 && m == STRETCH) scl_drv = 1'b1;
                    m++;
                    @(negedge clk);
                end
                check("R11 high time", m, FLT + 3 + th + ((th == 2) ? STRETCH : 0));
                wait_irq();
                check("R5 master sample", rx_bit, 1);
                check("R6 master full", rx_full, 1);
                check("R7 master tx ok", tx_empty, 1);
                // Lost bit: bus pulls SDA low against a sent 1
                do_wr(1'b1);
                sda_drv = 1'b0;
                pulse_clr(1'b0);
                cycles(2);
                wait_irq();
                check("R7 lost bit", tx_empty, 0);
                check("R5 lost bit sample", rx_bit, 0);
                sda_drv = 1'b1;
                // Release and STOP
                do_wr(1'b0);
                pulse_clr(1'b1);
                cycles(40);
                check("R12 released", scl_oe, 0);
                do_wr(1'b1);
                cycles(15);
                check("R4 master stop", bus_busy, 0);
                check("R9 irq cleared", bit_irq, 0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule